// File: doc/BRIEF.md
# Dual-Clock Decoupling Queue with Early Full Flag

This block passes data words from a producer on one clock to a consumer on a second clock. The two clocks may have any frequency ratio and any phase relationship. Each side keeps its own binary pointer and publishes a gray-coded copy of it. The other side receives that copy through a two-flop synchronizer, so each side judges occupancy from a slightly stale view of the far pointer.

The full flag is raised when the write side sees the nominal depth occupied. The storage array is larger than the nominal depth: it holds the nominal depth plus a slack count, rounded up to a power of two. A producer that writes every cycle and reacts to full one cycle late still lands its extra word safely. The consumer sees the oldest word on the read data port whenever empty is low, and pops it with a read enable.

Top module: `xdom_queue`

## Requirements
- R1: While either reset is held, and right after both are released, full_o is 0 and empty_o is 1.
- R2: Every word written while the queue accepts writes is delivered to the consumer exactly once, in write order.
- R3: With no reads, full_o stays 0 after DEPTH_N-1 writes and is 1 once the DEPTH_N-th write has been taken.
- R4: The physical depth is DEPTH_N+SLACK_S rounded up to a power of two. A producer that writes once more after full_o has risen has that write accepted and delivered.
- R5: When empty_o is 0, rd_data_o shows the oldest stored word, and a read-clock edge with rd_en_i high removes exactly that word.
- R6: A read enable while empty_o is 1 has no effect. A word written afterwards is the first word shown and read.
- R7: After a write into an empty queue, empty_o is still 1 at the first falling read-clock edge after the write edge, and is 0 within three read-clock cycles after that.
- R8: After one read from a queue holding DEPTH_N words, full_o is still 1 at the first falling write-clock edge after the read edge, and is 0 within three write-clock cycles after that.
- R9: The pointer copy sent across the clock boundary changes in at most one bit per cycle of its own clock.
- R10: While the queue is partly occupied, one write per write-clock edge and one read per read-clock edge proceed at the same time with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Producer clock |
| wr_rst_ni | input | 1 | Producer-side asynchronous reset, active low |
| wr_en_i | input | 1 | Write request for this write-clock edge |
| wr_data_i | input | DATA_W | Word to store |
| full_o | output | 1 | Early full: nominal depth reached as seen by the write side |
| rclk_i | input | 1 | Consumer clock |
| rd_rst_ni | input | 1 | Consumer-side asynchronous reset, active low |
| rd_en_i | input | 1 | Read request for this read-clock edge |
| rd_data_o | output | DATA_W | Oldest stored word, valid while empty_o is 0 |
| empty_o | output | 1 | No word visible to the consumer |

## Verification
A write pointer that skips or stalls shows up on the next word the consumer pops, as a wrong or repeated value. That word can appear as soon as the synchronizer delay of two to three read cycles has passed. A broken gray conversion or occupancy subtraction moves the full or empty flag off its expected edge by one or more cycles. A flag that never falls would stall the producer or consumer, and the per-phase delivery count would then come up short. A missing slack entry makes the late write overwrite an unread word, so the consumer sees the order break within one queue depth of reads.

// File: rtl/xq_pkg.sv
package xq_pkg;
  function automatic int pow2_ceil(input int v);
    int p;
    p = 1;
    for (int i = 0; i < 31; i++) if (p < v) p = p << 1;
    return p;
  endfunction
endpackage

// File: rtl/xq_ram.sv
module xq_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int ENTRIES = 1 << AW;
  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/xq_sync.sv
module xq_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/xq_wr_ctrl.sv
module xq_wr_ctrl #(
  parameter int N  = 8,
  parameter int AW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [AW:0] rgray_sync_i,
  output logic [AW:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic        wr_fire_o,
  output logic        full_o
);
  localparam int PW   = AW + 1;
  localparam int PHYS = 1 << AW;

  logic [PW-1:0] wbin, wbin_nxt, rbin_seen, occ;
  logic          hard_full;

  always_comb begin
    rbin_seen[PW-1] = rgray_sync_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_seen[i] = rbin_seen[i+1] ^ rgray_sync_i[i];
  end

  assign occ       = wbin - rbin_seen;
  assign hard_full = (occ == PW'(PHYS));
  assign wr_fire_o = wr_en_i && !hard_full;
  assign wbin_nxt  = wbin + PW'(1);
  assign full_o    = (occ >= PW'(N));
  assign waddr_o   = wbin[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin    <= '0;
      wgray_o <= '0;
    end else if (wr_fire_o) begin
      wbin    <= wbin_nxt;
      wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  AST_WGRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wgray_o ^ $past(wgray_o))); // R9
  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= PW'(PHYS)); // R4
  AST_WPTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire_o |=> wbin == PW'($past(wbin) + 1'b1)); // R2
endmodule

// File: rtl/xq_rd_ctrl.sv
module xq_rd_ctrl #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [AW:0]   wgray_sync_i,
  output logic [AW:0]   rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          empty_o
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nxt;
  logic          rd_fire;

  assign empty_o  = (rgray_o == wgray_sync_i);
  assign rd_fire  = rd_en_i && !empty_o;
  assign rbin_nxt = rbin + PW'(1);
  assign raddr_o  = rbin[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin    <= '0;
      rgray_o <= '0;
    end else if (rd_fire) begin
      rbin    <= rbin_nxt;
      rgray_o <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  AST_RGRAY_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rgray_o ^ $past(rgray_o))); // R9
  AST_EMPTY_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i) |=> $stable(rbin)); // R6
  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire |=> rbin == PW'($past(rbin) + 1'b1)); // R5
endmodule

// File: rtl/xdom_queue.sv
module xdom_queue #(
  parameter int DEPTH_N = 8,
  parameter int DATA_W  = 8,
  parameter int SLACK_S = 4
) (
  input  logic              wclk_i,
  input  logic              wr_rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              rd_rst_ni,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o
);
  localparam int PHYS = xq_pkg::pow2_ceil(DEPTH_N + SLACK_S);
  localparam int AW   = $clog2(PHYS);
  localparam int PW   = AW + 1;

  logic [PW-1:0] wgray, rgray, wgray_at_rd, rgray_at_wr;
  logic [AW-1:0] waddr, raddr;
  logic          wr_fire;

  xq_wr_ctrl #(.N(DEPTH_N), .AW(AW)) u_wr (
    .clk_i(wclk_i), .rst_ni(wr_rst_ni), .wr_en_i(wr_en_i),
    .rgray_sync_i(rgray_at_wr), .wgray_o(wgray), .waddr_o(waddr),
    .wr_fire_o(wr_fire), .full_o(full_o)
  );

  xq_rd_ctrl #(.AW(AW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rd_rst_ni), .rd_en_i(rd_en_i),
    .wgray_sync_i(wgray_at_rd), .rgray_o(rgray), .raddr_o(raddr),
    .empty_o(empty_o)
  );

  xq_sync #(.W(PW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rd_rst_ni), .d_i(wgray), .q_o(wgray_at_rd)
  );

  xq_sync #(.W(PW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(wr_rst_ni), .d_i(rgray), .q_o(rgray_at_wr)
  );

  xq_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .wclk_i(wclk_i), .we_i(wr_fire), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(rd_data_o)
  );
endmodule

// File: tb/tb_xdom_queue.sv
`timescale 1ns/1ps
module tb_xdom_queue;
  localparam int N  = 8;
  localparam int DW = 8;
  // entry: [15:8] words, [7:4] write-slot mask, [3:0] read-slot mask
  localparam logic [15:0] VEC [0:5] = '{16'h28FF, 16'h28F1, 16'h1E5F,
                                       16'h28F3, 16'h1996, 16'h20FE};

  logic wclk = 0, rclk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;
  int checks = 0, errors = 0, late = 0;
  logic [DW-1:0] sb [64];
  int sb_head = 0, sb_tail = 0;

  always #4 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  xdom_queue #(.DEPTH_N(N), .DATA_W(DW), .SLACK_S(4)) dut (
    .wclk_i(wclk), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .rclk_i(rclk), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .empty_o(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic produce(input int cnt, input logic [3:0] wm, input int ph);
    bit full_seen = 0;
    int sent = 0;
    int cyc = 0;
    while (sent < cnt) begin
      @(negedge wclk);
      wr_en = wm[cyc%4] && !full_seen;
      if (wr_en) begin
        wr_data = DW'(ph * 37 + sent);
        sb[sb_tail%64] = wr_data;
        sb_tail++;
        if (full) late++;
        sent++;
      end
      full_seen = full;
      cyc++;
    end
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic consume(input int cnt, input logic [3:0] rm);
    int got = 0;
    for (int c = 0; c < 3000 && got < cnt; c++) begin
      @(negedge rclk);
      rd_en = rm[c%4];
      if (rd_en && !empty) begin
        chk(rd_data == sb[sb_head%64], "R2 order", rd_data, sb[sb_head%64]);
        sb_head++;
        got++;
      end
    end
    @(negedge rclk);
    rd_en = 0;
    chk(got == cnt, "R10 delivered count", got, cnt);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wclk);
    chk(full == 0, "R1 full in reset", full, 0);
    chk(empty == 1, "R1 empty in reset", empty, 1);
    wr_rst_n = 1;
    rd_rst_n = 1;
    repeat (3) @(negedge rclk);
    chk(full == 0, "R1 full after reset", full, 0);
    chk(empty == 1, "R1 empty after reset", empty, 1);

    foreach (VEC[v]) begin
      fork
        produce(int'(VEC[v][15:8]), VEC[v][7:4], v);
        consume(int'(VEC[v][15:8]), VEC[v][3:0]);
      join
    end
    chk(late > 0, "R4 late write taken", late, 1);
    repeat (6) @(negedge rclk);

    // R3: fill to nominal depth with reads stalled
    for (int k = 0; k <= N; k++) begin
      @(negedge wclk);
      if (k == N - 1) chk(full == 0, "R3 full before Nth", full, 0);
      if (k == N) chk(full == 1, "R3 full at N", full, 1);
      wr_en = (k < N);
      wr_data = DW'(8'h40 + k);
    end
    wr_en = 0;
    repeat (4) @(negedge rclk);

    // R8: one read, full drops only after synchronization
    @(negedge rclk);
    rd_en = 1;
    chk(rd_data == 8'h40, "R5 oldest word", rd_data, 8'h40);
    @(posedge rclk);
    @(negedge wclk);
    rd_en = 0;
    chk(full == 1, "R8 full held", full, 1);
    repeat (3) @(negedge wclk);
    chk(full == 0, "R8 full released", full, 0);

    for (int k = 1; k < N; k++) begin
      @(negedge rclk);
      rd_en = 1;
      chk(rd_data == DW'(8'h40 + k), "R5 drain order", rd_data, 8'h40 + k);
    end
    @(negedge rclk);
    rd_en = 0;
    chk(empty == 1, "R5 empty after drain", empty, 1);

    // R6: reads into empty queue are ignored
    repeat (4) begin
      @(negedge rclk);
      rd_en = 1;
      chk(empty == 1, "R6 empty held", empty, 1);
    end
    @(negedge rclk);
    rd_en = 0;

    // R7: write into empty queue, visibility delay
    @(negedge wclk);
    wr_en = 1;
    wr_data = 8'hA5;
    @(posedge wclk);
    #1 wr_en = 0;
    @(negedge rclk);
    chk(empty == 1, "R7 empty still set", empty, 1);
    repeat (3) @(negedge rclk);
    chk(empty == 0, "R7 empty cleared", empty, 0);
    chk(rd_data == 8'hA5, "R6 first word after ignored reads", rd_data, 8'hA5);
    rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
    chk(empty == 1, "R5 single pop empties", empty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule